// File: doc/BRIEF.md
# Multi-Register Byte Table Lookup

This unit translates a vector of sixteen byte indexes into sixteen result bytes. Each index picks one byte out of a lookup table. The table is built from one to four 16-byte table registers, so an index can reach up to 64 table bytes. All sixteen lanes are looked up in parallel. The result is captured in an output register one clock after a valid input.

An index can point past the active table. A 2-bit policy input chooses what happens then:
- force the result byte to zero;
- keep the matching byte of a prior destination vector;
- zero the byte only when index bit 7 is set, and otherwise look up from the first register alone;
- wrap the index into the table so that every index lands on a real entry.

A second 2-bit input sets how many table registers are active. Typical uses are byte permutes, byte translation through a small table, and character-class lookups in a data-parallel datapath. The table, index and prior-destination vectors are supplied by the surrounding datapath.

Top module: `byte_table_lookup`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` becomes 0 and `result_o` becomes all zeros.
- R2: `out_valid` is 1 exactly in the cycle after an edge where `in_valid` was 1. `result_o` only changes at edges where `in_valid` is 1, and holds otherwise.
- R3: Table entry `a` (0 to 63) is byte `a mod 16` of table register `a / 16`. Register `r` occupies `table_i[r*128 +: 128]`, and byte `b` of a register occupies bits `[b*8 +: 8]`. Lane `k` of `idx_i`, `prior_i` and `result_o` occupies bits `[k*8 +: 8]`.
- R4: `regs_m1` values 0, 1, 2 and 3 select 1, 2, 3 and 4 active table registers. The active table size S is 16 times that count.
- R5: With `policy` = 0 (zeroing), an index below S returns table entry `index`, and an index of S or more returns 0.
- R6: With `policy` = 1 (merging), an index below S returns table entry `index`, and an index of S or more returns the `prior_i` byte of the same lane.
- R7: With `policy` = 2 (sign-bit), an index with bit 7 set returns 0. Otherwise the lane returns byte `index mod 16` of register 0, whatever `regs_m1` is.
- R8: With `policy` = 3 (wrapping), the lane returns table entry `index mod P`. P is 16 times the largest power of two not above the active register count, so P is 32 when three registers are active.
- R9: Each lane depends only on its own index byte and its own prior byte. Different lanes may hit, miss and wrap in the same transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs are valid and the result register loads this cycle |
| policy | input | 2 | Out-of-range policy: 0 zero, 1 merge, 2 sign-bit, 3 wrap |
| regs_m1 | input | 2 | Active table registers minus one |
| table_i | input | 512 | Four 16-byte table registers, register 0 in the low bits |
| idx_i | input | 128 | Sixteen index bytes |
| prior_i | input | 128 | Sixteen prior destination bytes used by the merge policy |
| out_valid | output | 1 | Result register was loaded at the last edge |
| result_o | output | 128 | Sixteen registered result bytes |

## Verification
The embedded properties check these on every clock, in every lane:
- the valid latency and the holding of the result between transactions;
- zeroing of out-of-range indexes under the zero and sign-bit policies;
- carry-over of the prior byte under the merge policy;
- that any table address the index logic produces lies inside the active table.

The value actually returned for in-range indexes can only be shown by the bench's scenarios. The same holds for the wrap modulus, including the three-register case, and for the register-0-only reach of the sign-bit policy. The bench sweeps all 256 index values under every policy and register count, against a table whose 64 bytes are all distinct.

// File: rtl/tbl_lookup_pkg.sv
// Package: shared types for the byte table lookup unit.
// Assumes: policy encoding is fixed by the top-level port contract.
package tbl_lookup_pkg;

    // Out-of-range handling policy, encoded as on the policy port
    typedef enum logic [1:0] {
        POL_ZERO    = 2'd0,
        POL_MERGE   = 2'd1,
        POL_SIGNBIT = 2'd2,
        POL_WRAP    = 2'd3
    } oob_policy_e;

    // What a lane does with its index after policy resolution
    typedef enum logic [1:0] {
        ACT_TABLE = 2'd0,
        ACT_ZERO  = 2'd1,
        ACT_KEEP  = 2'd2
    } lane_act_e;

endpackage

// File: rtl/tbl_index_map.sv
// Module: tbl_index_map
// Resolves one index byte into a table address and a lane action
// (take table byte, force zero, keep prior byte) under the selected policy.
// Assumes: REG_BYTES and MAX_REGS are powers of two, MAX_REGS >= 2,
// and IDX_W is wide enough to cover the whole table.
module tbl_index_map
    import tbl_lookup_pkg::*;
#(
    parameter int unsigned REG_BYTES = 16,
    parameter int unsigned MAX_REGS  = 4,
    parameter int unsigned IDX_W     = 8
) (
    input  logic [IDX_W-1:0]                     idx_i,
    input  logic [$clog2(MAX_REGS)-1:0]          regs_m1_i,
    input  oob_policy_e                          policy_i,
    output logic [$clog2(REG_BYTES*MAX_REGS)-1:0] addr_o,
    output lane_act_e                            act_o
);
    localparam int unsigned SEL_W  = $clog2(REG_BYTES);
    localparam int unsigned CNT_W  = $clog2(MAX_REGS);
    localparam int unsigned ADDR_W = $clog2(REG_BYTES * MAX_REGS);

    logic [CNT_W:0]  reg_cnt;
    logic [CNT_W:0]  pow2_cnt;
    logic [ADDR_W:0] active_size;
    logic [ADDR_W:0] wrap_span;
    logic [ADDR_W:0] wrap_mask;
    logic            in_range;

    // Active table size and the largest power-of-two span inside it
    always_comb begin
        reg_cnt     = (CNT_W+1)'(regs_m1_i) + (CNT_W+1)'(1);
        active_size = (ADDR_W+1)'(reg_cnt) << SEL_W;
        pow2_cnt    = (CNT_W+1)'(1);
        for (int b = 0; b <= CNT_W; b++) begin
            if (reg_cnt >= (CNT_W+1)'(1 << b))
                pow2_cnt = (CNT_W+1)'(1 << b);
        end
        wrap_span = (ADDR_W+1)'(pow2_cnt) << SEL_W;
        wrap_mask = wrap_span - (ADDR_W+1)'(1);
        in_range  = int'(idx_i) < int'(active_size);
    end

    // Policy resolution: address and action for this lane
    always_comb begin
        addr_o = idx_i[ADDR_W-1:0];
        act_o  = ACT_TABLE;
        unique case (policy_i)
            POL_ZERO:    if (!in_range) act_o = ACT_ZERO;
            POL_MERGE:   if (!in_range) act_o = ACT_KEEP;
            POL_SIGNBIT: begin
                addr_o = ADDR_W'(idx_i[SEL_W-1:0]);
                if (idx_i[IDX_W-1]) act_o = ACT_ZERO;
            end
            POL_WRAP:    addr_o = idx_i[ADDR_W-1:0] & wrap_mask[ADDR_W-1:0];
            default:     act_o = ACT_ZERO;
        endcase
    end

endmodule

// File: rtl/tbl_byte_mux.sv
// Module: tbl_byte_mux
// Selects one byte of the flattened table: entry a is byte (a mod REG_BYTES)
// of register (a / REG_BYTES), which is simply byte a of the flat vector.
// Assumes: REG_BYTES*MAX_REGS is a power of two so every address is valid.
module tbl_byte_mux #(
    parameter int unsigned REG_BYTES = 16,
    parameter int unsigned MAX_REGS  = 4
) (
    input  logic [REG_BYTES*MAX_REGS*8-1:0]       table_i,
    input  logic [$clog2(REG_BYTES*MAX_REGS)-1:0] addr_i,
    output logic [7:0]                            byte_o
);
    localparam int unsigned TBL_BYTES = REG_BYTES * MAX_REGS;

    logic [7:0] entry [TBL_BYTES];

    // Split the flat table into addressable entries
    for (genvar g = 0; g < TBL_BYTES; g++) begin : g_entry
        assign entry[g] = table_i[g*8 +: 8];
    end

    // Address-driven selection
    assign byte_o = entry[addr_i];

endmodule

// File: rtl/byte_table_lookup.sv
// Module: byte_table_lookup (top)
// Sixteen parallel byte lookups into a table of one to four 16-byte registers,
// with a selectable out-of-range policy and a registered result.
// Assumes: synchronous active-low reset; inputs are sampled only when in_valid.
module byte_table_lookup
    import tbl_lookup_pkg::*;
#(
    parameter int unsigned LANES     = 16,
    parameter int unsigned REG_BYTES = 16,
    parameter int unsigned MAX_REGS  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [1:0]                      policy,
    input  logic [$clog2(MAX_REGS)-1:0]     regs_m1,
    input  logic [REG_BYTES*MAX_REGS*8-1:0] table_i,
    input  logic [LANES*8-1:0]              idx_i,
    input  logic [LANES*8-1:0]              prior_i,
    output logic                            out_valid,
    output logic [LANES*8-1:0]              result_o
);
    localparam int unsigned ADDR_W = $clog2(REG_BYTES * MAX_REGS);
    localparam int unsigned VEC_W  = LANES * 8;

    oob_policy_e      pol;
    logic [VEC_W-1:0] result_d;
    int               active_bytes;

    assign pol          = oob_policy_e'(policy);
    assign active_bytes = (int'(regs_m1) + 1) * int'(REG_BYTES);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ADDR_W-1:0] addr;
        lane_act_e         act;
        logic [7:0]        tbyte;

        tbl_index_map #(
            .REG_BYTES (REG_BYTES),
            .MAX_REGS  (MAX_REGS),
            .IDX_W     (8)
        ) u_map (
            .idx_i     (idx_i[k*8 +: 8]),
            .regs_m1_i (regs_m1),
            .policy_i  (pol),
            .addr_o    (addr),
            .act_o     (act)
        );

        tbl_byte_mux #(
            .REG_BYTES (REG_BYTES),
            .MAX_REGS  (MAX_REGS)
        ) u_mux (
            .table_i (table_i),
            .addr_i  (addr),
            .byte_o  (tbyte)
        );

        // Lane result: table byte, zero, or prior destination byte
        always_comb begin
            unique case (act)
                ACT_TABLE: result_d[k*8 +: 8] = tbyte;
                ACT_KEEP:  result_d[k*8 +: 8] = prior_i[k*8 +: 8];
                default:   result_d[k*8 +: 8] = 8'h00;
            endcase
        end

        AST_ADDR_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && act == ACT_TABLE) |-> (int'(addr) < active_bytes)); // R4
        AST_ZERO_POLICY_OOB: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && policy == 2'd0 && int'(idx_i[k*8 +: 8]) >= active_bytes)
            |=> (result_o[k*8 +: 8] == 8'h00)); // R5
        AST_MERGE_KEEPS_PRIOR: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && policy == 2'd1 && int'(idx_i[k*8 +: 8]) >= active_bytes)
            |=> (result_o[k*8 +: 8] == $past(prior_i[k*8 +: 8]))); // R6
        AST_SIGNBIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && policy == 2'd2 && idx_i[k*8 + 7])
            |=> (result_o[k*8 +: 8] == 8'h00)); // R7
    end

    // Output register: load on valid, hold otherwise, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result_o  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result_o <= result_d;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result_o))); // R2

endmodule

// File: tb/byte_table_lookup_tb.sv
`timescale 1ns/1ps
// Bench: exhaustive index sweep over every policy and active register count.
module byte_table_lookup_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   policy = '0;
    logic [1:0]   regs_m1 = '0;
    logic [511:0] table_i = '0;
    logic [127:0] idx_i = '0;
    logic [127:0] prior_i = '0;
    logic         out_valid;
    logic [127:0] result_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    byte_table_lookup u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .policy    (policy),
        .regs_m1   (regs_m1),
        .table_i   (table_i),
        .idx_i     (idx_i),
        .prior_i   (prior_i),
        .out_valid (out_valid),
        .result_o  (result_o)
    );

    // Distinct content for all 64 table entries (37 is odd, so no repeats)
    function automatic logic [7:0] tval(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // Expected lane result from the requirements
    function automatic logic [7:0] model(int pol, int n, int idx, logic [7:0] pr);
        int sz = n * 16;
        int p;
        case (pol)
            0: return (idx < sz) ? tval(idx) : 8'h00;                 // R5
            1: return (idx < sz) ? tval(idx) : pr;                    // R6
            2: return (idx >= 128) ? 8'h00 : tval(idx % 16);          // R7
            default: begin                                            // R8
                p = (n >= 4) ? 4 : (n >= 2) ? 2 : 1;
                return tval(idx % (p * 16));
            end
        endcase
    endfunction

    function automatic string tag(int pol);
        case (pol)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [127:0] got, logic [127:0] exp, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    initial begin
        logic [127:0] expv;
        logic [127:0] held;
        // Table layout per R3: entry a at table_i[a*8 +: 8]
        for (int a = 0; a < 64; a++) table_i[a*8 +: 8] = tval(a);

        repeat (3) @(negedge clk);
        check("R1", {127'd0, out_valid}, 128'd0, "out_valid in reset");
        check("R1", result_o, 128'd0, "result in reset");
        rst_n = 1'b1;

        for (int pol = 0; pol < 4; pol++) begin
            for (int n = 1; n <= 4; n++) begin
                for (int blk = 0; blk < 16; blk++) begin
                    @(negedge clk);
                    policy   = 2'(pol);
                    regs_m1  = 2'(n - 1);      // R4 encoding
                    in_valid = 1'b1;
                    for (int k = 0; k < 16; k++) begin
                        // R9: lanes carry scrambled, different indexes
                        idx_i[k*8 +: 8]   = 8'(blk * 16 + ((k * 5 + blk) & 15));
                        prior_i[k*8 +: 8] = 8'(8'hC3 ^ (k * 17 + blk));
                        expv[k*8 +: 8]    = model(pol, n, blk * 16 + ((k * 5 + blk) & 15),
                                                  8'(8'hC3 ^ (k * 17 + blk)));
                    end
                    @(negedge clk);
                    in_valid = 1'b0;
                    check("R2", {127'd0, out_valid}, 128'd1, "out_valid after valid");
                    check(tag(pol), result_o, expv, $sformatf("pol %0d regs %0d blk %0d (R3 R9)", pol, n, blk));
                end
                // R2: inputs change without valid, result must hold
                held    = result_o;
                @(negedge clk);
                idx_i   = ~idx_i;
                prior_i = ~prior_i;
                policy  = ~policy;
                @(negedge clk);
                check("R2", {127'd0, out_valid}, 128'd0, "out_valid while idle");
                check("R2", result_o, held, "result held while idle");
            end
        end

        // R1: reset mid-run clears the outputs
        @(negedge clk);
        in_valid = 1'b1;
        rst_n    = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", {127'd0, out_valid}, 128'd0, "out_valid after reset");
        check("R1", result_o, 128'd0, "result after reset");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule